// File: doc/BRIEF.md
# Oscillator Auto-Trim Controller

This block keeps an on-chip oscillator near its target frequency. A reference timing window, marked by a strobe at each boundary, frames a count of oscillator cycles. The oscillator arrives as a one-cycle tick already brought into the system clock domain. When a window closes, the count is compared with three programmable values: a lower trigger, an ideal centre and an upper trigger. The block then nudges a 6-bit fine trim code or an 8-bit coarse calibration code, and both codes drive the oscillator's tuning input.

A count between the two triggers leaves the codes alone, so small drift causes no constant hunting. When a correction step carries the count from one side of the centre to the other, the block returns to whichever of the two settings landed nearer the centre. It then holds that setting until the frequency drifts further out than the setting it kept. A small word-addressed register port lets software program the three comparison values and read back both codes.

Top module: `osc_autotrim`

## Requirements
- R1: After reset the lower trigger reads 7980, the centre 8000 and the upper trigger 8020; the coarse code is 128 and the fine code is 32.
- R2: Register address 0 holds the lower trigger, 1 the centre and 2 the upper trigger, each 16 bits and read/write. Address 3 reads {2'b00, fine[5:0], coarse[7:0]}, and writes to it have no effect.
- R3: The window count is the number of cycles with osc_tick high between two win_strobe pulses, with both boundary counts inclusive at the triggers. The codes change only on the clock edge that samples win_strobe high.
- R4: A count strictly above the lower trigger and strictly below the upper trigger leaves both codes unchanged, unless it completes a crossing as in R8.
- R5: A count at or below the lower trigger raises the fine code by one. A count at or above the upper trigger lowers it by one.
- R6: When the fine code is already at its limit in the needed direction (63 going up, 0 going down), the coarse code steps by one instead and the fine code reloads to 32.
- R7: Both codes saturate: at coarse 255 with fine 63 a further raise is ignored, and at coarse 0 with fine 0 a further lower is ignored.
- R8: When the window right after a step lands on the other side of the centre from the window that caused the step, no step is made. The block keeps whichever of the two settings gave a count with the smaller distance from the centre.
- R9: On equal distances in R8, the setting with the lower code is kept.
- R10: After an R8 decision the codes hold. Stepping resumes only on a triggering count whose distance from the centre exceeds the distance of the setting that was kept.
- R11: While enable is low both codes hold and the window count stays cleared. The first window that closes after enable rises is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Enables counting and code adjustment |
| osc_tick | input | 1 | One pulse per oscillator cycle, synchronous to clk |
| win_strobe | input | 1 | Reference window boundary pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cal_code | output | 8 | Coarse calibration code to the oscillator |
| trim_code | output | 6 | Fine trim code to the oscillator |

## Verification
The main loop feeds a scripted sequence of window counts. These include counts exactly on each trigger, counts inside the dead band, and step pairs that cross the centre with the first count nearer, the second count nearer, or both at equal distance. Together they separate a correct dead band from an off-by-one compare, and a correct cross-return from one that always keeps or always restores. Long runs of low and high counts drive the fine code into its limits, which shows whether the coarse carry reloads the midpoint and whether both ends saturate. Enable toggling, with trigger-worthy counts in the discarded window, shows that partial windows never move a code.

// File: rtl/osc_autotrim.sv
module osc_autotrim #(
  parameter int CNT_W  = 16,
  parameter int CAL_W  = 8,
  parameter int TRIM_W = 6,
  parameter logic [CNT_W-1:0] LO_RST  = 16'd7980,
  parameter logic [CNT_W-1:0] MID_RST = 16'd8000,
  parameter logic [CNT_W-1:0] HI_RST  = 16'd8020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              osc_tick,
  input  logic              win_strobe,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [CAL_W-1:0]  cal_code,
  output logic [TRIM_W-1:0] trim_code
);
  localparam logic [CAL_W-1:0]  CAL_MAX  = '1;
  localparam logic [CAL_W-1:0]  CAL_MID  = {1'b1, {(CAL_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam int PAD_W = CNT_W - CAL_W - TRIM_W;

  logic [CNT_W-1:0]  lo_q, mid_q, hi_q, cnt_q, prev_cnt_q, best_q;
  logic [CAL_W-1:0]  cal_q, prev_cal_q, cal_step;
  logic [TRIM_W-1:0] trim_q, prev_trim_q, trim_step;
  logic primed_q, stepped_q, up_q, locked_q, moved;

  assign cal_code  = cal_q;
  assign trim_code = trim_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = lo_q;
      2'd1:    reg_rdata = mid_q;
      2'd2:    reg_rdata = hi_q;
      default: reg_rdata = {{PAD_W{1'b0}}, trim_q, cal_q};
    endcase
  end

  wire trig_lo = cnt_q <= lo_q;
  wire trig_hi = !trig_lo && cnt_q >= hi_q;
  wire [CNT_W-1:0] d_cur  = (cnt_q >= mid_q) ? cnt_q - mid_q : mid_q - cnt_q;
  wire [CNT_W-1:0] d_prev = (prev_cnt_q >= mid_q) ? prev_cnt_q - mid_q : mid_q - prev_cnt_q;
  wire crossed = stepped_q &&
                 (((cnt_q < mid_q) && (prev_cnt_q > mid_q)) ||
                  ((cnt_q > mid_q) && (prev_cnt_q < mid_q)));
  wire take_prev = (d_prev < d_cur) || ((d_prev == d_cur) && up_q);
  wire want_step = (trig_lo || trig_hi) && (!locked_q || d_cur > best_q);

  always_comb begin
    cal_step  = cal_q;
    trim_step = trim_q;
    moved     = 1'b0;
    if (trig_lo) begin
      if (trim_q != TRIM_MAX) begin
        trim_step = trim_q + 1'b1;
        moved     = 1'b1;
      end else if (cal_q != CAL_MAX) begin
        cal_step  = cal_q + 1'b1;
        trim_step = TRIM_MID;
        moved     = 1'b1;
      end
    end else if (trig_hi) begin
      if (trim_q != '0) begin
        trim_step = trim_q - 1'b1;
        moved     = 1'b1;
      end else if (cal_q != '0) begin
        cal_step  = cal_q - 1'b1;
        trim_step = TRIM_MID;
        moved     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= LO_RST;  mid_q <= MID_RST;  hi_q <= HI_RST;
      cal_q <= CAL_MID;  trim_q <= TRIM_MID;
      prev_cal_q <= CAL_MID;  prev_trim_q <= TRIM_MID;
      cnt_q <= '0;  prev_cnt_q <= '0;  best_q <= '0;
      primed_q <= 1'b0;  stepped_q <= 1'b0;  up_q <= 1'b0;  locked_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    lo_q  <= reg_wdata;
          2'd1:    mid_q <= reg_wdata;
          2'd2:    hi_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (!enable) begin
        cnt_q <= '0;  primed_q <= 1'b0;  stepped_q <= 1'b0;  locked_q <= 1'b0;
      end else if (win_strobe) begin
        cnt_q    <= {{(CNT_W-1){1'b0}}, osc_tick};
        primed_q <= 1'b1;
        if (primed_q) begin
          if (crossed) begin
            if (take_prev) begin
              cal_q  <= prev_cal_q;
              trim_q <= prev_trim_q;
            end
            best_q    <= take_prev ? d_prev : d_cur;
            locked_q  <= 1'b1;
            stepped_q <= 1'b0;
          end else if (want_step) begin
            locked_q    <= 1'b0;
            stepped_q   <= moved;
            up_q        <= trig_lo;
            prev_cnt_q  <= cnt_q;
            prev_cal_q  <= cal_q;
            prev_trim_q <= trim_q;
            cal_q       <= cal_step;
            trim_q      <= trim_step;
          end else begin
            stepped_q <= 1'b0;
          end
        end
      end else if (osc_tick && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module osc_autotrim_chk #(
  parameter int CNT_W  = 16,
  parameter int CAL_W  = 8,
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              win_strobe,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic [CNT_W-1:0]  lo_q,
  input logic [CNT_W-1:0]  hi_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              primed_q,
  input logic              stepped_q,
  input logic [CAL_W-1:0]  cal_code,
  input logic [TRIM_W-1:0] trim_code
);
  // R11
  codes_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(cal_code) && $stable(trim_code)));
  // R3
  codes_only_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_strobe |=> ($stable(cal_code) && $stable(trim_code)));
  // R4
  dead_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_strobe && enable && primed_q && !stepped_q && cnt_q > lo_q && cnt_q < hi_q)
    |=> ($stable(cal_code) && $stable(trim_code)));
  // R2
  lower_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (lo_q == $past(reg_wdata)));
  // R6
  coarse_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_strobe && enable && primed_q && !stepped_q && cnt_q <= lo_q &&
     trim_code == '1 && cal_code != '1)
    |=> (trim_code == {1'b1, {(TRIM_W-1){1'b0}}} && cal_code == $past(cal_code) + 1'b1));
endmodule

bind osc_autotrim osc_autotrim_chk #(.CNT_W(CNT_W), .CAL_W(CAL_W), .TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .win_strobe(win_strobe),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .lo_q(lo_q), .hi_q(hi_q), .cnt_q(cnt_q), .primed_q(primed_q),
  .stepped_q(stepped_q), .cal_code(cal_code), .trim_code(trim_code)
);

// File: tb/sim_osc_autotrim.sv
`timescale 1ns/1ps
module sim_osc_autotrim;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, osc_tick = 1'b0, win_strobe = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [7:0] cal_code;
  logic [5:0] trim_code;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  osc_autotrim u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_tick(osc_tick),
    .win_strobe(win_strobe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cal_code(cal_code), .trim_code(trim_code)
  );

  localparam int NV = 14;
  localparam int VEC_CNT  [NV] = '{100, 90, 95, 103, 96, 104, 96, 110, 106, 98, 101, 90, 112, 100};
  localparam int VEC_TRIM [NV] = '{ 32, 33, 34,  34, 35,  34, 34,  33,  32, 32,  32, 33,  32,  32};
  localparam string VEC_REQ [NV] = '{"R4", "R5", "R5", "R8", "R10", "R9", "R10",
                                     "R10", "R5", "R8", "R10", "R10", "R8", "R10"};

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
    end
    @(negedge clk); osc_tick = 1'b0; win_strobe = 1'b1;
    @(negedge clk); win_strobe = 1'b0;
  endtask

  task automatic windows(int k, int n);
    for (int j = 0; j < k; j++) window(n);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic codes(string req, int exp_cal, int exp_trim);
    check(req, cal_code, exp_cal);
    check(req, trim_code, exp_trim);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_900_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); check("R1", d, 7980);
    rd(2'd1, d); check("R1", d, 8000);
    rd(2'd2, d); check("R1", d, 8020);
    codes("R1", 128, 32);
    // R2 register map
    wr(2'd0, 16'd96); wr(2'd1, 16'd100); wr(2'd2, 16'd104);
    rd(2'd0, d); check("R2", d, 96);
    rd(2'd1, d); check("R2", d, 100);
    rd(2'd2, d); check("R2", d, 104);
    wr(2'd3, 16'h0000);
    rd(2'd3, d); check("R2", d, (32 << 8) | 128);
    // R11 disabled: trigger-worthy window does nothing
    window(50); codes("R11", 128, 32);
    // R11 first window after enable discarded
    enable = 1'b1;
    window(50); codes("R11", 128, 32);
    // vector walk: R3..R10
    for (int v = 0; v < NV; v++) begin
      window(VEC_CNT[v]);
      codes(VEC_REQ[v], 128, VEC_TRIM[v]);
    end
    // R11 hold while disabled
    enable = 1'b0;
    windows(2, 50); codes("R11", 128, 32);
    // saturation runs with tiny thresholds
    wr(2'd0, 16'd2); wr(2'd1, 16'd4); wr(2'd2, 16'd6);
    enable = 1'b1;
    window(7); codes("R11", 128, 32);
    windows(32, 7); codes("R5", 128, 0);
    window(7); codes("R6", 127, 32);
    windows(4300, 7); codes("R7", 0, 0);
    window(7); codes("R7", 0, 0);
    windows(63, 1); codes("R5", 0, 63);
    window(1); codes("R6", 1, 32);
    windows(9000, 1); codes("R7", 255, 63);
    window(1); codes("R7", 255, 63);
    window(7); codes("R5", 255, 62);
    rd(2'd3, d); check("R2", d, (62 << 8) | 255);
    summary();
  end
endmodule